// File: doc/BRIEF.md
# I2C Target Register Access Engine

This block is an I2C target that gives a bus controller byte access to a bank of nine 8-bit locations. It samples SCL and SDA through a short synchroniser, finds START, repeated START and STOP in the system clock domain, and checks an identification byte built from a fixed 4-bit prefix and three strap pins. Then it either loads a location pointer and streams write bytes into the bank, or streams bank contents back to the controller. The pointer advances after every data byte and wraps from the last location to location 0. SDA is only ever pulled low through `sda_pull`. The system clock must run at least about eight times faster than SCL.

Toward the register bank the block offers a location index, write data and a one-cycle write strobe. It expects read data to return combinationally for the index it presents. It also gives a one-cycle pulse when a STOP closes a transaction that carried a matching identification byte, so the bank can begin a non-volatile commit. While `boot_busy` is high (power-up recall still running) the engine is held in its idle state and ignores START.

The state machine has these states. `ST_IDLE` waits for START. `ST_ID` receives the identification byte. `ST_ID_ACK` acknowledges a match and leaves for `ST_RDAT` when R/W is 1 or `ST_PTR` when it is 0. `ST_PTR` receives the pointer. `ST_PTR_ACK` acknowledges it and moves to `ST_WDAT`. `ST_WDAT` receives a data byte. `ST_WDAT_ACK` acknowledges it and returns to `ST_WDAT`. `ST_RDAT` sends a byte. `ST_RACK` samples the controller's acknowledge and returns to `ST_RDAT` on ACK or goes to `ST_SKIP` on NACK. An ID mismatch also leads to `ST_SKIP`, which releases SDA and ignores traffic. From any state, START leads to `ST_ID`, STOP leads to `ST_IDLE`, and `boot_busy` forces `ST_IDLE`.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_pull`, `reg_we` and `stop_pulse` are 0 and `reg_addr` is 0.
- R2: An identification byte whose bits 7:4 are 1010 and whose bits 3:1 equal `strap[2:0]` is acknowledged by pulling SDA low for the ninth SCL clock. Bit 0 selects read (1) or write (0).
- R3: A non-matching identification byte (wrong prefix or wrong strap bits) is not acknowledged. The engine then acknowledges nothing and writes nothing until the next START.
- R4: In a write, the pointer byte and every data byte are acknowledged. Each data byte produces exactly one single-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, and `reg_addr` holds steady in the cycle after the strobe.
- R5: The pointer increments by one after each data byte written, and location 8 is followed by location 0.
- R6: A pointer byte with a value above 8 loads the pointer with 0.
- R7: After a repeated START with a read identification byte, the engine sends the byte at the pointer MSB first, changing SDA only after SCL falls. It then increments the pointer, wrapping 8 to 0, and sends the next byte for as long as the controller acknowledges.
- R8: A controller NACK after a read byte ends transmission, and SDA stays released for any further SCL clocks until START or STOP.
- R9: STOP returns the engine to idle. `stop_pulse` is a single-cycle pulse issued only for a STOP that ends a transaction with a matching identification byte.
- R10: While `boot_busy` is 1, START is ignored: no acknowledge, no `reg_we`, no `stop_pulse`, and from the next cycle on SDA is released.
- R11: `reg_addr` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_busy | input | 1 | Power-up recall in progress; engine held idle |
| strap | input | 3 | Address strap pins compared with ID bits 3:1 |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 4 | Bank location index (pointer) |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Bank contents at `reg_addr` |
| stop_pulse | output | 1 | One-cycle pulse on STOP after a matched transaction |

## Verification
The hardest case to reach is the silent state after a controller NACK. At that point the target must keep SDA released while SCL keeps toggling, and the only way in is a full read transaction ending in a refused byte. The stimulus runs a dummy write, a repeated START and a read, answers the first byte with NACK, and then clocks nine more SCL pulses with SDA released while checking that the line never goes low. The wrap from location 8 to 0 is reached in both directions by multi-byte transfers that start at location 7.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } tgt_state_t;

    localparam logic [3:0] ID_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;
    logic              scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int NLOC = 9,
    parameter int AW   = $clog2(NLOC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(NLOC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= (int'(load_val) < NLOC) ? load_val[AW-1:0] : '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int NLOC = 9,
    parameter int DW   = 8,
    parameter int SYNC = 2,
    localparam int AW  = $clog2(NLOC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_busy,
    input  logic [2:0]    strap,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_pull,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata,
    output logic          stop_pulse
);

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);

    tgt_state_t    state, nxt;
    logic          sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] rx_sr, tx_sr;
    logic          mack, addressed, we_q, stop_q;
    logic [DW-1:0] wdata_q;
    logic          byte_done, id_ok, rx_state, ptr_load, ptr_step;

    i2c_tgt_cond #(.STAGES(SYNC)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2c_tgt_ptr #(.NLOC(NLOC), .AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val(rx_sr[7:0]),
        .step    (ptr_step),
        .ptr     (reg_addr)
    );

    assign byte_done = scl_fall && (bitcnt == FULL);
    assign id_ok     = (rx_sr[7:4] == ID_PREFIX) && (rx_sr[3:1] == strap);
    assign rx_state  = (state == ST_ID) || (state == ST_PTR) || (state == ST_WDAT);
    assign ptr_load  = (state == ST_PTR) && (nxt == ST_PTR_ACK);
    assign ptr_step  = ((state == ST_WDAT_ACK) && (nxt == ST_WDAT)) ||
                       ((state == ST_RDAT) && (nxt == ST_RACK));

    // next-state decision
    always_comb begin
        nxt = state;
        if (boot_busy) begin
            nxt = ST_IDLE;
        end else if (bus_start) begin
            nxt = ST_ID;
        end else if (bus_stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ID:       if (byte_done) nxt = id_ok ? ST_ID_ACK : ST_SKIP;
                ST_ID_ACK:   if (scl_fall)  nxt = rx_sr[0] ? ST_RDAT : ST_PTR;
                ST_PTR:      if (byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall)  nxt = ST_WDAT;
                ST_WDAT:     if (byte_done) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall)  nxt = ST_WDAT;
                ST_RDAT:     if (byte_done) nxt = ST_RACK;
                ST_RACK:     if (scl_fall)  nxt = mack ? ST_RDAT : ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sr     <= '0;
            tx_sr     <= '1;
            mack      <= 1'b0;
            addressed <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
            stop_q    <= 1'b0;
        end else begin
            if (nxt != state)
                bitcnt <= '0;
            else if (scl_rise && (rx_state || state == ST_RDAT))
                bitcnt <= bitcnt + 1'b1;

            if (scl_rise && rx_state)
                rx_sr <= {rx_sr[DW-2:0], sda_lvl};

            if (nxt == ST_RDAT && state != ST_RDAT)
                tx_sr <= reg_rdata;
            else if (state == ST_RDAT && scl_fall && bitcnt != FULL)
                tx_sr <= {tx_sr[DW-2:0], 1'b1};

            if (state == ST_RACK && scl_rise)
                mack <= ~sda_lvl;

            if (boot_busy || bus_start || bus_stop)
                addressed <= 1'b0;
            else if (state == ST_ID && nxt == ST_ID_ACK)
                addressed <= 1'b1;

            we_q <= (state == ST_WDAT) && (nxt == ST_WDAT_ACK);
            if ((state == ST_WDAT) && (nxt == ST_WDAT_ACK))
                wdata_q <= rx_sr;

            stop_q <= bus_stop && addressed && !boot_busy;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ID_ACK, ST_PTR_ACK, ST_WDAT_ACK: sda_pull = 1'b1;
            ST_RDAT:                            sda_pull = ~tx_sr[DW-1];
            default:                            sda_pull = 1'b0;
        endcase
        reg_we     = we_q;
        reg_wdata  = wdata_q;
        stop_pulse = stop_q;
    end

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
    parameter int NLOC = 9,
    parameter int AW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boot_busy,
    input logic          sda_pull,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic          stop_pulse
);

    // R11
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr <= AW'(NLOC - 1));

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    we_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $stable(reg_addr));

    // R9
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_busy |=> (!sda_pull && !reg_we));

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NLOC(NLOC), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_busy (boot_busy),
    .sda_pull  (sda_pull),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .stop_pulse(stop_pulse)
);

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;

    localparam int Q = 5;
    localparam int H = 10;
    localparam logic [7:0] ID_W = 8'hAA;   // 1010 + strap 101 + write
    localparam logic [7:0] ID_R = 8'hAB;   // 1010 + strap 101 + read

    // {op[3:0], pointer[7:0], data[7:0]}; op 1 = write, 2 = read/expect
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {4'h1, 8'h00, 8'h3C},
        {4'h1, 8'h05, 8'hA7},
        {4'h1, 8'h08, 8'hF1},
        {4'h2, 8'h00, 8'h3C},
        {4'h2, 8'h05, 8'hA7},
        {4'h2, 8'h08, 8'hF1},
        {4'h1, 8'h03, 8'h00},
        {4'h2, 8'h03, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_busy = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull, reg_we, stop_pulse;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] bank [9];
    int         we_cnt, stop_cnt, wide_we;
    logic       we_prev;
    int         vectors = 0, misses = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign reg_rdata = (reg_addr < 4'd9) ? bank[reg_addr] : 8'h00;

    i2c_reg_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_busy (boot_busy),
        .strap     (3'b101),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .stop_pulse(stop_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) bank[i] <= 8'h00;
            we_cnt <= 0; stop_cnt <= 0; wide_we <= 0; we_prev <= 1'b0;
        end else begin
            if (reg_we) begin
                bank[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (stop_pulse) stop_cnt <= stop_cnt + 1;
            if (reg_we && we_prev) wide_we <= wide_we + 1;
            we_prev <= reg_we;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(Q); scl_m = 1'b1; wait_n(Q);
        sda_m = 1'b0; wait_n(Q); scl_m = 1'b0; wait_n(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(Q); scl_m = 1'b1; wait_n(Q);
        sda_m = 1'b1; wait_n(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(Q);
            scl_m = 1'b1; wait_n(H);
            scl_m = 1'b0; wait_n(Q);
        end
        sda_m = 1'b1; wait_n(Q);
        scl_m = 1'b1; wait_n(H / 2);
        acked = ~sda_line;
        wait_n(H / 2);
        scl_m = 1'b0; wait_n(Q);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_n(Q);
            scl_m = 1'b1; wait_n(H / 2);
            b[i] = sda_line;
            wait_n(H / 2);
            scl_m = 1'b0;
        end
        wait_n(Q);
        sda_m = ~give_ack; wait_n(Q);
        scl_m = 1'b1; wait_n(H);
        scl_m = 1'b0; wait_n(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_seq(input logic [7:0] ptr, input logic [23:0] bytes,
                             input int n, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        put_byte(ID_W, a); all_ack &= a;
        put_byte(ptr, a);  all_ack &= a;
        for (int k = 0; k < n; k++) begin
            put_byte(bytes[23 - 8*k -: 8], a); all_ack &= a;
        end
        bus_stop();
        wait_n(H);
    endtask

    task automatic read_seq(input logic [7:0] ptr, input int n,
                            output logic [23:0] got, output logic all_ack);
        logic a;
        logic [7:0] b;
        all_ack = 1'b1;
        got = '0;
        bus_start();
        put_byte(ID_W, a); all_ack &= a;
        put_byte(ptr, a);  all_ack &= a;
        bus_start();
        put_byte(ID_R, a); all_ack &= a;
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, b);
            got[23 - 8*k -: 8] = b;
        end
        bus_stop();
        wait_n(H);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++; misses++;
            $display("FAIL R9 watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic ok;
        logic [23:0] got;
        logic [7:0] b;
        int we0, st0, lows;

        wait_n(4);
        check("R1 sda_pull after reset", sda_pull, 0);
        check("R1 reg_we after reset", reg_we, 0);
        check("R1 stop_pulse after reset", stop_pulse, 0);
        check("R1 reg_addr after reset", reg_addr, 0);
        rst_n = 1'b1;
        wait_n(4);

        // table walk: R2, R4, R7
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][19:16] == 4'h1) begin
                write_seq(VEC[v][15:8], {VEC[v][7:0], 16'h0}, 1, ok);
                check($sformatf("R2/R4 write acks vec %0d", v), ok, 1);
                check($sformatf("R4 bank write vec %0d", v), bank[VEC[v][11:8]], VEC[v][7:0]);
            end else begin
                read_seq(VEC[v][15:8], 1, got, ok);
                check($sformatf("R2 read acks vec %0d", v), ok, 1);
                check($sformatf("R7 read data vec %0d", v), got[23:16], VEC[v][7:0]);
            end
        end
        check("R9 stop pulses after table", stop_cnt, NV);
        check("R4 write strobes after table", we_cnt, 4);

        // R5: write wraps 8 -> 0
        write_seq(8'h07, 24'h112233, 3, ok);
        check("R5 burst acks", ok, 1);
        check("R5 loc 7", bank[7], 8'h11);
        check("R5 loc 8", bank[8], 8'h22);
        check("R5 loc 0 after wrap", bank[0], 8'h33);

        // R7: read wraps 8 -> 0
        read_seq(8'h07, 3, got, ok);
        check("R7 burst read acks", ok, 1);
        check("R7 burst read data", got, 24'h112233);

        // R6: pointer above 8 loads 0
        write_seq(8'h0C, 24'h5A0000, 1, ok);
        check("R6 out-of-range pointer acks", ok, 1);
        check("R6 out-of-range pointer writes loc 0", bank[0], 8'h5A);

        // R3: strap mismatch then prefix mismatch
        we0 = we_cnt; st0 = stop_cnt;
        bus_start();
        put_byte(8'hA8, ok);
        check("R3 strap mismatch no ack", ok, 0);
        put_byte(8'h02, ok);
        check("R3 pointer ignored", ok, 0);
        put_byte(8'hEE, ok);
        check("R3 data ignored", ok, 0);
        bus_stop();
        wait_n(H);
        check("R3 no write after mismatch", we_cnt, we0);
        check("R9 no stop pulse after mismatch", stop_cnt, st0);
        bus_start();
        put_byte(8'hBA, ok);
        check("R3 prefix mismatch no ack", ok, 0);
        bus_stop();
        wait_n(H);

        // R8: NACK then SDA stays released
        bus_start();
        put_byte(ID_W, ok);
        put_byte(8'h08, ok);
        bus_start();
        put_byte(ID_R, ok);
        get_byte(1'b0, b);
        check("R8 byte before NACK", b, 8'h22);
        lows = 0;
        for (int p = 0; p < 9; p++) begin
            wait_n(Q); scl_m = 1'b1; wait_n(H / 2);
            if (!sda_line) lows++;
            wait_n(H / 2); scl_m = 1'b0; wait_n(Q);
            if (!sda_line) lows++;
        end
        check("R8 SDA released after NACK", lows, 0);
        bus_stop();
        wait_n(H);

        // R10: busy ignores a full write
        we0 = we_cnt; st0 = stop_cnt;
        boot_busy = 1'b1;
        write_seq(8'h02, 24'h990000, 1, ok);
        check("R10 no ack while busy", ok, 0);
        check("R10 no write while busy", we_cnt, we0);
        check("R10 no stop pulse while busy", stop_cnt, st0);
        boot_busy = 1'b0;
        wait_n(4);
        write_seq(8'h02, 24'h990000, 1, ok);
        check("R10 write after busy clears", bank[2], 8'h99);

        check("R4 write strobe single cycle", wide_we, 0);
        check("R11 reg_addr in range at end", reg_addr <= 4'd8, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule